// File: doc/BRIEF.md
# Three-State Coherency Line Controller

This block keeps the coherency state of every line in a small direct-mapped cache whose lines are either Modified, Exclusive or Invalid; there is no Shared state. Each cycle it can take one local access (read or write, with caching-inhibited and write-through qualifiers) and one snooped bus transaction. From these it decides what the local side must put on the shared bus, whether a dirty line has to be written back, and how the line states change.

All cacheable reads count as reads that intend to modify. Locally, a cacheable read miss goes onto the bus as a burst read-with-intent-to-modify. On the snoop side, a cacheable burst read from another master evicts the matching line from this cache. A snooped single-beat read counts as caching-inhibited: a dirty line is pushed to memory and kept as a clean Exclusive copy. Because no line is ever shared, the cache stays coherent next to masters that run either a three-state or a four-state protocol. Data movement and bus arbitration belong to other blocks. All outputs are registered and appear in the cycle after the request.

Line addresses are split into an index (low bits) and a tag (high bits). Line states are encoded Invalid = 2'b00, Exclusive = 2'b01, Modified = 2'b11. Bus transfer codes are single-beat read = 2'b01, burst read-with-intent-to-modify = 2'b10, single-beat write = 2'b11.

Top module: `mei_line_ctrl`

## Requirements
- R1: After synchronous reset every line is Invalid, so the first cacheable read of any address misses, and no output pulse is active.
- R2: A cacheable local read miss issues a bus request one cycle later with code 2'b10, burst asserted and the line address, and installs the line as Exclusive (2'b01). A later read of it hits with no bus request.
- R3: A caching-inhibited local read issues code 2'b01 and a caching-inhibited local write issues code 2'b11, both without burst. Neither allocates a line nor changes any line state.
- R4: A local write hit on an Exclusive line makes it Modified (2'b11) with no bus request. A cacheable, non-write-through write miss issues code 2'b10 with burst and installs the line as Modified.
- R5: A write-through write issues code 2'b11 without burst. On a hit the line state is unchanged, and on a miss no line is allocated.
- R6: A miss that replaces a Modified line of a different tag raises the castout pulse with the victim's line address, in the same cycle as the fill request.
- R7: A snooped write, or a snooped cacheable burst read, that hits an Exclusive line invalidates it and pushes nothing.
- R8: A snooped write, or a snooped cacheable burst read, that hits a Modified line raises the push pulse with the line address and invalidates the line.
- R9: A snooped read that is single-beat or caching-inhibited is handled as caching-inhibited. A Modified hit is pushed and becomes Exclusive without being invalidated, and an Exclusive hit is left unchanged.
- R10: A snoop whose tag does not match the indexed line, or that finds it Invalid, causes no push, no invalidation and no state change.
- R11: When a snoop and a local access hit the same line in one cycle, the snoop is applied first and the local access is judged against the post-snoop state.
- R12: A completed local access raises a done pulse with a hit flag and the line state after the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| loc_valid | input | 1 | Local access present this cycle |
| loc_write | input | 1 | Local access is a write |
| loc_inhibit | input | 1 | Local access is caching-inhibited |
| loc_wthru | input | 1 | Local write is write-through |
| loc_addr | input | 12 | Local line address {tag, index} |
| snp_valid | input | 1 | Snooped transaction present this cycle |
| snp_read | input | 1 | Snooped transaction is a read (else a write) |
| snp_burst | input | 1 | Snooped transaction is a burst |
| snp_inhibit | input | 1 | Snooped transaction is caching-inhibited |
| snp_addr | input | 12 | Snooped line address {tag, index} |
| bus_req_valid | output | 1 | Local bus request pulse |
| bus_ttype | output | 2 | Bus transfer code |
| bus_burst | output | 1 | Bus request is a burst |
| bus_addr | output | 12 | Bus request line address |
| castout_valid | output | 1 | Modified victim must be written back |
| castout_addr | output | 12 | Victim line address |
| snp_push_valid | output | 1 | Snooped Modified line must be pushed |
| snp_push_addr | output | 12 | Pushed line address |
| snp_inval | output | 1 | Snoop invalidated a line |
| loc_done | output | 1 | Local access completed |
| loc_hit | output | 1 | Local access hit (post-snoop) |
| loc_state | output | 2 | Line state after the local access |

## Verification
Snoop handling and a local update can fall in the same cycle, on the same line. The bench drives both in one cycle to a line the snoop evicts: first a local read against an Exclusive line, then a local write against a Modified line under a snooped write. The result counts as correct only if the snoop's push and invalidation appear, the local access reports a miss with a fresh burst fill, and no castout is raised for the line the snoop already emptied.

// File: rtl/mei_pkg.sv
package mei_pkg;
  typedef enum logic [1:0] {
    LS_INV = 2'b00,
    LS_EXC = 2'b01,
    LS_MOD = 2'b11
  } line_st_e;

  typedef enum logic [1:0] {
    TT_NONE  = 2'b00,
    TT_READ  = 2'b01,
    TT_RWITM = 2'b10,
    TT_WRITE = 2'b11
  } ttype_e;
endpackage

// File: rtl/mei_tag_store.sv
module mei_tag_store import mei_pkg::*; #(
  parameter int IDX_W = 4,
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] s_idx,
  output line_st_e         s_st,
  output logic [TAG_W-1:0] s_tag,
  input  logic             s_we,
  input  line_st_e         s_wst,
  input  logic [IDX_W-1:0] l_idx,
  output line_st_e         l_st,
  output logic [TAG_W-1:0] l_tag,
  input  logic             l_we,
  input  line_st_e         l_wst,
  input  logic [TAG_W-1:0] l_wtag
);
  localparam int LINES = 1 << IDX_W;

  line_st_e         st_q  [LINES];
  logic [TAG_W-1:0] tag_q [LINES];

  assign s_st  = st_q[s_idx];
  assign s_tag = tag_q[s_idx];
  assign l_st  = st_q[l_idx];
  assign l_tag = tag_q[l_idx];

  // state: local write is issued last so it wins on a shared index
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LINES; i++) st_q[i] <= LS_INV;
    end else begin
      if (s_we) st_q[s_idx] <= s_wst;
      if (l_we) st_q[l_idx] <= l_wst;
    end
  end

  // tags need no reset: an Invalid state masks them
  always_ff @(posedge clk) begin
    if (l_we) tag_q[l_idx] <= l_wtag;
  end
endmodule

// File: rtl/mei_snoop_eval.sv
module mei_snoop_eval import mei_pkg::*; #(
  parameter int TAG_W = 8
) (
  input  logic             valid,
  input  logic             is_read,
  input  logic             burst,
  input  logic             inhibit,
  input  logic [TAG_W-1:0] tag_in,
  input  line_st_e         cur_st,
  input  logic [TAG_W-1:0] cur_tag,
  output logic             we,
  output line_st_e         new_st,
  output logic             push,
  output logic             inval
);
  logic hit, as_inhibited;

  assign hit          = valid && (cur_st != LS_INV) && (cur_tag == tag_in);
  assign as_inhibited = is_read && (inhibit || !burst);

  always_comb begin
    new_st = cur_st;
    push   = 1'b0;
    if (hit) begin
      push   = (cur_st == LS_MOD);
      new_st = as_inhibited ? LS_EXC : LS_INV;
    end
    we    = hit && (new_st != cur_st);
    inval = hit && (new_st == LS_INV);
  end
endmodule

// File: rtl/mei_local_eval.sv
module mei_local_eval import mei_pkg::*; #(
  parameter int TAG_W = 8
) (
  input  logic             valid,
  input  logic             write,
  input  logic             inhibit,
  input  logic             wthru,
  input  logic [TAG_W-1:0] tag_in,
  input  line_st_e         cur_st,
  input  logic [TAG_W-1:0] cur_tag,
  output logic             bus_v,
  output ttype_e           ttype,
  output logic             burst,
  output logic             we,
  output line_st_e         new_st,
  output logic             castout,
  output logic             hit
);
  assign hit = (cur_st != LS_INV) && (cur_tag == tag_in);

  always_comb begin
    bus_v   = 1'b0;
    ttype   = TT_NONE;
    burst   = 1'b0;
    we      = 1'b0;
    new_st  = cur_st;
    castout = 1'b0;
    if (valid) begin
      if (inhibit) begin
        bus_v = 1'b1;
        ttype = write ? TT_WRITE : TT_READ;
      end else if (write && wthru) begin
        bus_v = 1'b1;
        ttype = TT_WRITE;
      end else if (hit) begin
        if (write) begin
          we     = (cur_st != LS_MOD);
          new_st = LS_MOD;
        end
      end else begin
        bus_v   = 1'b1;
        ttype   = TT_RWITM;
        burst   = 1'b1;
        we      = 1'b1;
        new_st  = write ? LS_MOD : LS_EXC;
        castout = (cur_st == LS_MOD);
      end
    end
  end
endmodule

// File: rtl/mei_line_ctrl.sv
module mei_line_ctrl import mei_pkg::*; #(
  parameter int IDX_W = 4,
  parameter int TAG_W = 8,
  localparam int LINE_W = IDX_W + TAG_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              loc_valid,
  input  logic              loc_write,
  input  logic              loc_inhibit,
  input  logic              loc_wthru,
  input  logic [LINE_W-1:0] loc_addr,
  input  logic              snp_valid,
  input  logic              snp_read,
  input  logic              snp_burst,
  input  logic              snp_inhibit,
  input  logic [LINE_W-1:0] snp_addr,
  output logic              bus_req_valid,
  output logic [1:0]        bus_ttype,
  output logic              bus_burst,
  output logic [LINE_W-1:0] bus_addr,
  output logic              castout_valid,
  output logic [LINE_W-1:0] castout_addr,
  output logic              snp_push_valid,
  output logic [LINE_W-1:0] snp_push_addr,
  output logic              snp_inval,
  output logic              loc_done,
  output logic              loc_hit,
  output logic [1:0]        loc_state
);
  logic [IDX_W-1:0] s_idx, l_idx;
  logic [TAG_W-1:0] s_tag_in, l_tag_in;
  assign s_idx    = snp_addr[IDX_W-1:0];
  assign s_tag_in = snp_addr[LINE_W-1:IDX_W];
  assign l_idx    = loc_addr[IDX_W-1:0];
  assign l_tag_in = loc_addr[LINE_W-1:IDX_W];

  line_st_e         s_st, l_st_raw, l_st_post, s_new, l_new;
  logic [TAG_W-1:0] s_tag, l_tag;
  logic             s_we, s_push, s_inv;
  logic             l_we, l_bus, l_burst, l_cast, l_hit;
  ttype_e           l_tt;

  mei_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_store (
    .clk(clk), .rst(rst),
    .s_idx(s_idx), .s_st(s_st), .s_tag(s_tag), .s_we(s_we), .s_wst(s_new),
    .l_idx(l_idx), .l_st(l_st_raw), .l_tag(l_tag), .l_we(l_we), .l_wst(l_new),
    .l_wtag(l_tag_in)
  );

  mei_snoop_eval #(.TAG_W(TAG_W)) u_snoop (
    .valid(snp_valid), .is_read(snp_read), .burst(snp_burst),
    .inhibit(snp_inhibit), .tag_in(s_tag_in), .cur_st(s_st), .cur_tag(s_tag),
    .we(s_we), .new_st(s_new), .push(s_push), .inval(s_inv)
  );

  // snoop goes first: the local side sees the post-snoop line state
  assign l_st_post = (s_we && (s_idx == l_idx)) ? s_new : l_st_raw;

  mei_local_eval #(.TAG_W(TAG_W)) u_local (
    .valid(loc_valid), .write(loc_write), .inhibit(loc_inhibit),
    .wthru(loc_wthru), .tag_in(l_tag_in), .cur_st(l_st_post), .cur_tag(l_tag),
    .bus_v(l_bus), .ttype(l_tt), .burst(l_burst), .we(l_we), .new_st(l_new),
    .castout(l_cast), .hit(l_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_req_valid  <= 1'b0;
      bus_ttype      <= TT_NONE;
      bus_burst      <= 1'b0;
      bus_addr       <= '0;
      castout_valid  <= 1'b0;
      castout_addr   <= '0;
      snp_push_valid <= 1'b0;
      snp_push_addr  <= '0;
      snp_inval      <= 1'b0;
      loc_done       <= 1'b0;
      loc_hit        <= 1'b0;
      loc_state      <= LS_INV;
    end else begin
      bus_req_valid  <= l_bus;
      bus_ttype      <= l_tt;
      bus_burst      <= l_burst;
      bus_addr       <= loc_addr;
      castout_valid  <= l_cast;
      castout_addr   <= {l_tag, l_idx};
      snp_push_valid <= s_push;
      snp_push_addr  <= snp_addr;
      snp_inval      <= s_inv;
      loc_done       <= loc_valid;
      loc_hit        <= loc_valid && l_hit;
      loc_state      <= l_new;
    end
  end

  // R2
  rwitm_is_burst_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_req_valid && bus_ttype == TT_RWITM) |-> bus_burst);

  // R3
  inhibit_no_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (loc_valid && loc_inhibit) |=> (bus_req_valid && !bus_burst && !castout_valid));

  // R6
  castout_with_fill_chk: assert property (@(posedge clk) disable iff (rst)
    castout_valid |-> (bus_req_valid && bus_ttype == TT_RWITM));

  // R8
  push_needs_snoop_chk: assert property (@(posedge clk) disable iff (rst)
    snp_push_valid |-> $past(snp_valid));

  // R9
  single_beat_keeps_chk: assert property (@(posedge clk) disable iff (rst)
    (snp_valid && snp_read && !snp_burst) |=> !snp_inval);

  // R12
  done_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    loc_done |-> $past(loc_valid));
endmodule

// File: tb/tb_mei_line_ctrl.sv
`timescale 1ns/1ps
module tb_mei_line_ctrl;
  localparam int IDX_W = 4;
  localparam int TAG_W = 8;
  localparam int LW = IDX_W + TAG_W;

  logic clk = 1'b0;
  logic rst;
  logic loc_valid, loc_write, loc_inhibit, loc_wthru;
  logic [LW-1:0] loc_addr;
  logic snp_valid, snp_read, snp_burst, snp_inhibit;
  logic [LW-1:0] snp_addr;
  logic bus_req_valid, bus_burst, castout_valid, snp_push_valid, snp_inval;
  logic loc_done, loc_hit;
  logic [1:0] bus_ttype, loc_state;
  logic [LW-1:0] bus_addr, castout_addr, snp_push_addr;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  mei_line_ctrl #(.IDX_W(IDX_W), .TAG_W(TAG_W)) dut (
    .clk(clk), .rst(rst),
    .loc_valid(loc_valid), .loc_write(loc_write), .loc_inhibit(loc_inhibit),
    .loc_wthru(loc_wthru), .loc_addr(loc_addr),
    .snp_valid(snp_valid), .snp_read(snp_read), .snp_burst(snp_burst),
    .snp_inhibit(snp_inhibit), .snp_addr(snp_addr),
    .bus_req_valid(bus_req_valid), .bus_ttype(bus_ttype), .bus_burst(bus_burst),
    .bus_addr(bus_addr), .castout_valid(castout_valid), .castout_addr(castout_addr),
    .snp_push_valid(snp_push_valid), .snp_push_addr(snp_push_addr),
    .snp_inval(snp_inval), .loc_done(loc_done), .loc_hit(loc_hit),
    .loc_state(loc_state)
  );

  function automatic logic [LW-1:0] la(int tag, int idx);
    return {tag[TAG_W-1:0], idx[IDX_W-1:0]};
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic idle();
    loc_valid = 0; loc_write = 0; loc_inhibit = 0; loc_wthru = 0; loc_addr = '0;
    snp_valid = 0; snp_read = 0; snp_burst = 0; snp_inhibit = 0; snp_addr = '0;
  endtask

  // one cycle with optional local and snoop request; outputs sampled after the edge
  task automatic step(bit lv, bit lw, bit li, bit lt, logic [LW-1:0] la_,
                      bit sv, bit sr, bit sb, bit si, logic [LW-1:0] sa);
    @(negedge clk);
    loc_valid = lv; loc_write = lw; loc_inhibit = li; loc_wthru = lt; loc_addr = la_;
    snp_valid = sv; snp_read = sr; snp_burst = sb; snp_inhibit = si; snp_addr = sa;
    @(posedge clk);
    #1;
    idle();
  endtask

  task automatic lrd(logic [LW-1:0] a);
    step(1, 0, 0, 0, a, 0, 0, 0, 0, '0);
  endtask
  task automatic lwr(logic [LW-1:0] a);
    step(1, 1, 0, 0, a, 0, 0, 0, 0, '0);
  endtask
  task automatic snp(bit rd, bit bst, bit inh, logic [LW-1:0] a);
    step(0, 0, 0, 0, '0, 1, rd, bst, inh, a);
  endtask

  task automatic t_reset();
    chk("R1", "bus_req after reset", bus_req_valid, 0);
    chk("R1", "push after reset", snp_push_valid, 0);
    chk("R1", "done after reset", loc_done, 0);
    lrd(la(1, 1));
    chk("R1", "first read hit", loc_hit, 0);
    chk("R2", "miss bus_req", bus_req_valid, 1);
    chk("R2", "miss ttype", bus_ttype, 2);
    chk("R2", "miss burst", bus_burst, 1);
    chk("R2", "miss addr", bus_addr, la(1, 1));
    chk("R2", "fill state", loc_state, 1);
    chk("R12", "done pulse", loc_done, 1);
    lrd(la(1, 1));
    chk("R2", "reread hit", loc_hit, 1);
    chk("R2", "reread no bus", bus_req_valid, 0);
  endtask

  task automatic t_inhibit();
    step(1, 0, 1, 0, la(2, 2), 0, 0, 0, 0, '0);
    chk("R3", "inh read ttype", bus_ttype, 1);
    chk("R3", "inh read burst", bus_burst, 0);
    step(1, 1, 1, 0, la(2, 2), 0, 0, 0, 0, '0);
    chk("R3", "inh write ttype", bus_ttype, 3);
    chk("R3", "inh write burst", bus_burst, 0);
    lrd(la(2, 2));
    chk("R3", "no allocate", loc_hit, 0);
    step(1, 1, 1, 0, la(2, 2), 0, 0, 0, 0, '0);
    lrd(la(2, 2));
    chk("R3", "inh write kept state", loc_state, 1);
  endtask

  task automatic t_write();
    lwr(la(1, 1));
    chk("R4", "write hit no bus", bus_req_valid, 0);
    chk("R4", "write hit state", loc_state, 3);
    lwr(la(3, 3));
    chk("R4", "write miss ttype", bus_ttype, 2);
    chk("R4", "write miss burst", bus_burst, 1);
    chk("R4", "write miss state", loc_state, 3);
  endtask

  task automatic t_wthru();
    step(1, 1, 0, 1, la(4, 4), 0, 0, 0, 0, '0);
    chk("R5", "wt ttype", bus_ttype, 3);
    chk("R5", "wt burst", bus_burst, 0);
    lrd(la(4, 4));
    chk("R5", "wt miss no allocate", loc_hit, 0);
    step(1, 1, 0, 1, la(1, 1), 0, 0, 0, 0, '0);
    chk("R5", "wt hit state", loc_state, 3);
    chk("R5", "wt hit flag", loc_hit, 1);
  endtask

  task automatic t_castout();
    lrd(la(9, 1));
    chk("R6", "castout pulse", castout_valid, 1);
    chk("R6", "castout addr", castout_addr, la(1, 1));
    chk("R6", "fill ttype", bus_ttype, 2);
    chk("R6", "new line state", loc_state, 1);
    lrd(la(10, 2));
    chk("R6", "clean victim no castout", castout_valid, 0);
  endtask

  task automatic t_snoop_exc();
    snp(1, 1, 0, la(9, 1));
    chk("R7", "E burst read inval", snp_inval, 1);
    chk("R7", "E no push", snp_push_valid, 0);
    lrd(la(9, 1));
    chk("R7", "line gone", loc_hit, 0);
    snp(0, 0, 0, la(9, 1));
    chk("R7", "E write snoop inval", snp_inval, 1);
  endtask

  task automatic t_snoop_mod();
    snp(0, 1, 0, la(3, 3));
    chk("R8", "M write snoop push", snp_push_valid, 1);
    chk("R8", "push addr", snp_push_addr, la(3, 3));
    chk("R8", "M write snoop inval", snp_inval, 1);
    lwr(la(5, 5));
    snp(1, 1, 0, la(5, 5));
    chk("R8", "M burst read push", snp_push_valid, 1);
    chk("R8", "M burst read inval", snp_inval, 1);
    lrd(la(5, 5));
    chk("R8", "line gone", loc_hit, 0);
  endtask

  task automatic t_snoop_single();
    lwr(la(6, 6));
    snp(1, 0, 0, la(6, 6));
    chk("R9", "single beat push", snp_push_valid, 1);
    chk("R9", "single beat no inval", snp_inval, 0);
    lrd(la(6, 6));
    chk("R9", "kept line hit", loc_hit, 1);
    chk("R9", "kept line clean", loc_state, 1);
    snp(1, 1, 1, la(6, 6));
    chk("R9", "inhibited on E push", snp_push_valid, 0);
    chk("R9", "inhibited on E inval", snp_inval, 0);
    lrd(la(6, 6));
    chk("R9", "E still hit", loc_hit, 1);
  endtask

  task automatic t_snoop_miss();
    snp(1, 1, 0, la(7, 6));
    chk("R10", "tag miss push", snp_push_valid, 0);
    chk("R10", "tag miss inval", snp_inval, 0);
    snp(0, 1, 0, la(7, 12));
    chk("R10", "invalid line inval", snp_inval, 0);
    lrd(la(6, 6));
    chk("R10", "line untouched", loc_state, 1);
  endtask

  task automatic t_concurrent();
    step(1, 0, 0, 0, la(6, 6), 1, 1, 1, 0, la(6, 6));
    chk("R11", "snoop inval first", snp_inval, 1);
    chk("R11", "local sees miss", loc_hit, 0);
    chk("R11", "refill ttype", bus_ttype, 2);
    chk("R11", "refill state", loc_state, 1);
    lwr(la(8, 8));
    step(1, 1, 0, 0, la(8, 8), 1, 0, 1, 0, la(8, 8));
    chk("R11", "push of M", snp_push_valid, 1);
    chk("R11", "no castout after snoop", castout_valid, 0);
    chk("R11", "write refill ttype", bus_ttype, 2);
    chk("R11", "write refill state", loc_state, 3);
    lrd(la(8, 8));
    chk("R12", "final hit", loc_hit, 1);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    idle();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_inhibit();
    t_write();
    t_wthru();
    t_castout();
    t_snoop_exc();
    t_snoop_mod();
    t_snoop_single();
    t_snoop_miss();
    t_concurrent();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule